// File: doc/BRIEF.md
# Vector Signed Widening Odd-Lane Multiplier

This block is the datapath for one vector multiply operation. Two source vectors of `VL` bits are cut into narrow signed lanes. Only the odd-numbered narrow lanes are used. The odd lane of operand A is multiplied by the matching odd lane of operand B. Each product is written into the double-width destination lane that covers that pair of narrow lanes.

A 2-bit width code picks the destination lane width at run time: 16, 32 or 64 bits, so sources of 8, 16 or 32 bits. Code 0 is reserved. Every destination lane is written on every operation; there is no masking.

The result appears after a fixed number of register stages, set by `LATENCY`. That delay does not depend on the operand values. `VL` must be a whole multiple of 64, and this is checked when the design is elaborated.

Top module: `odd_widen_mul`

## Requirements
- R1: With `in_size` = 2'b01, destination lane e (bits 16e+15..16e) holds the low 16 bits of the signed product of byte 2e+1 of A and byte 2e+1 of B, for all VL/16 lanes.
- R2: With `in_size` = 2'b10, destination lane e (bits 32e+31..32e) holds the low 32 bits of the signed product of 16-bit half-lane 2e+1 of A and of B, for all VL/32 lanes.
- R3: With `in_size` = 2'b11, destination lane e (bits 64e+63..64e) holds the signed product of 32-bit word 2e+1 of A and of B, for all VL/64 lanes.
- R4: The even-numbered narrow source lanes have no effect on the result.
- R5: Source lanes are two's complement. When both sources hold the most negative value, the positive result fits in the lane (-128 x -128 gives 16'h4000).
- R6: An accepted operation with `in_size` = 2'b00 raises `out_illegal` for one cycle, LATENCY cycles later. `out_valid` stays low in that cycle and `out_result` keeps its previous value. The two flags are never high together.
- R7: `out_valid` (or `out_illegal`) is high exactly LATENCY clock edges after an accepted `in_valid`, whatever the operand values. No output flag appears without a matching input.
- R8: `out_result` changes only when a legal operation completes. It holds its value while no legal result is delivered.
- R9: After synchronous reset, `out_valid` and `out_illegal` are low and `out_result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe, one per cycle |
| in_size | input | 2 | Width code: 01 = 16-bit, 10 = 32-bit, 11 = 64-bit results, 00 reserved |
| in_op_a | input | VL | First source vector |
| in_op_b | input | VL | Second source vector |
| out_valid | output | 1 | A legal result is on `out_result` |
| out_illegal | output | 1 | The operation completing now used the reserved code |
| out_result | output | VL | Destination vector |

## Verification
Two things can meet in one output cycle: a reserved-code completion and the result register left by the previous legal operation. The bench sends a legal operation and then a reserved-code operation straight after it. In the cycle where `out_illegal` rises it checks that `out_valid` is low and that `out_result` still holds the earlier product. A second collision is the signed overflow edge, where both odd sources are the most negative value. This is checked at all three widths against hand-computed values and against an independent bit-level reference model.

// File: rtl/odd_widen_mul_pkg.sv
package odd_widen_mul_pkg;

    localparam int CHUNK_W = 64;

    typedef enum logic [1:0] {
        WS_RSVD = 2'b00,
        WS_HALF = 2'b01,
        WS_WORD = 2'b10,
        WS_DBL  = 2'b11
    } wsize_e;

    typedef struct packed {
        wsize_e sel;
        logic   go;
        logic   bad;
    } op_ctl_t;

    // Odd-lane widening signed multiply over one 64-bit slice.
    function automatic logic [CHUNK_W-1:0] odd_mul_slice(
        input wsize_e             sel,
        input logic [CHUNK_W-1:0] a,
        input logic [CHUNK_W-1:0] b
    );
        logic [CHUNK_W-1:0] r;
        logic signed [15:0] xa16, xb16;
        logic signed [31:0] xa32, xb32;
        logic signed [63:0] xa64, xb64;
        r = '0;
        case (sel)
            WS_HALF: begin
                for (int e = 0; e < 4; e++) begin
                    xa16 = {{8{a[16*e+15]}}, a[16*e+8 +: 8]};
                    xb16 = {{8{b[16*e+15]}}, b[16*e+8 +: 8]};
                    r[16*e +: 16] = xa16 * xb16;
                end
            end
            WS_WORD: begin
                for (int e = 0; e < 2; e++) begin
                    xa32 = {{16{a[32*e+31]}}, a[32*e+16 +: 16]};
                    xb32 = {{16{b[32*e+31]}}, b[32*e+16 +: 16]};
                    r[32*e +: 32] = xa32 * xb32;
                end
            end
            WS_DBL: begin
                xa64 = {{32{a[63]}}, a[63:32]};
                xb64 = {{32{b[63]}}, b[63:32]};
                r = xa64 * xb64;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/owm_size_decode.sv
module owm_size_decode
    import odd_widen_mul_pkg::*;
(
    input  logic       valid,
    input  logic [1:0] code,
    output op_ctl_t    ctl
);
    always_comb begin
        ctl.sel = wsize_e'(code);
        ctl.bad = valid && (code == 2'b00);
        ctl.go  = valid && (code != 2'b00);
    end
endmodule

// File: rtl/owm_slice_mul.sv
module owm_slice_mul
    import odd_widen_mul_pkg::*;
(
    input  wsize_e             sel,
    input  logic [CHUNK_W-1:0] a,
    input  logic [CHUNK_W-1:0] b,
    output logic [CHUNK_W-1:0] r
);
    always_comb begin
        r = odd_mul_slice(sel, a, b);
    end

    // Most-negative byte pair in the lowest 16-bit lane must give +16384.
    always_comb begin
        if (sel == WS_HALF && a[15:8] == 8'h80 && b[15:8] == 8'h80)
            assert_minneg_R5: assert (r[15:0] == 16'h4000);
    end
endmodule

// File: rtl/owm_pipe.sv
module owm_pipe #(
    parameter int W     = 128,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go_in,
    input  logic         bad_in,
    input  logic [W-1:0] d_in,
    output logic         go_out,
    output logic         bad_out,
    output logic [W-1:0] d_out
);
    generate
        if (DEPTH == 0) begin : g_comb
            assign go_out  = go_in;
            assign bad_out = bad_in;
            assign d_out   = go_in ? d_in : '0;
        end else begin : g_reg
            logic [DEPTH-1:0] go_q, bad_q;
            logic [W-1:0]     d_q [DEPTH];

            always_ff @(posedge clk) begin
                if (rst) begin
                    go_q  <= '0;
                    bad_q <= '0;
                    for (int i = 0; i < DEPTH; i++) d_q[i] <= '0;
                end else begin
                    go_q[0]  <= go_in;
                    bad_q[0] <= bad_in;
                    if (go_in) d_q[0] <= d_in;
                    for (int i = 1; i < DEPTH; i++) begin
                        go_q[i]  <= go_q[i-1];
                        bad_q[i] <= bad_q[i-1];
                        if (go_q[i-1]) d_q[i] <= d_q[i-1];
                    end
                end
            end

            assign go_out  = go_q[DEPTH-1];
            assign bad_out = bad_q[DEPTH-1];
            assign d_out   = d_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/odd_widen_mul.sv
module odd_widen_mul
    import odd_widen_mul_pkg::*;
#(
    parameter int VL      = 128,
    parameter int LATENCY = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [1:0]    in_size,
    input  logic [VL-1:0] in_op_a,
    input  logic [VL-1:0] in_op_b,
    output logic          out_valid,
    output logic          out_illegal,
    output logic [VL-1:0] out_result
);
    localparam int SLICES = VL / CHUNK_W;

    generate
        if (VL % CHUNK_W != 0 || VL < CHUNK_W) begin : g_bad_vl
            $error("odd_widen_mul: VL must be a non-zero multiple of 64");
        end
    endgenerate

    op_ctl_t       ctl;
    logic [VL-1:0] prod;

    owm_size_decode u_dec (
        .valid (in_valid),
        .code  (in_size),
        .ctl   (ctl)
    );

    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        owm_slice_mul u_mul (
            .sel (ctl.sel),
            .a   (in_op_a[s*CHUNK_W +: CHUNK_W]),
            .b   (in_op_b[s*CHUNK_W +: CHUNK_W]),
            .r   (prod[s*CHUNK_W +: CHUNK_W])
        );
    end

    owm_pipe #(.W(VL), .DEPTH(LATENCY)) u_pipe (
        .clk     (clk),
        .rst     (rst),
        .go_in   (ctl.go),
        .bad_in  (ctl.bad),
        .d_in    (prod),
        .go_out  (out_valid),
        .bad_out (out_illegal),
        .d_out   (out_result)
    );

    always_comb begin
        assert_flag_excl_R6: assert (!(out_valid && out_illegal) || rst);
    end

    generate
        if (LATENCY > 0) begin : g_chk
            localparam int CW = $clog2(LATENCY + 1) + 1;
            logic [CW-1:0] inflight;
            logic          done_any;
            assign done_any = out_valid || out_illegal;

            always_ff @(posedge clk) begin
                if (rst) inflight <= '0;
                else     inflight <= inflight + CW'(in_valid) - CW'(done_any);
            end

            assert_no_orphan_R7: assert property (@(posedge clk) disable iff (rst)
                done_any |-> (inflight != '0));
            assert_bound_R7: assert property (@(posedge clk) disable iff (rst)
                inflight <= CW'(LATENCY));
            assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
                !out_valid |-> $stable(out_result));
        end
    endgenerate
endmodule

// File: tb/odd_widen_mul_bench.sv
`timescale 1ns/1ps
module odd_widen_mul_bench;
    localparam int VL  = 128;
    localparam int LAT = 2;
    localparam int NV  = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [1:0]    in_size = 2'b01;
    logic [VL-1:0] in_op_a = '0;
    logic [VL-1:0] in_op_b = '0;
    logic          out_valid, out_illegal;
    logic [VL-1:0] out_result;

    int n_run = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    odd_widen_mul #(.VL(VL), .LATENCY(LAT)) u_odd_widen_mul (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_size(in_size),
        .in_op_a(in_op_a), .in_op_b(in_op_b),
        .out_valid(out_valid), .out_illegal(out_illegal), .out_result(out_result)
    );

    localparam logic [1:0] TV_SZ [NV] = '{2'b01, 2'b01, 2'b10, 2'b10, 2'b11, 2'b11};
    localparam logic [VL-1:0] TV_A [NV] = '{
        {8{16'h8080}}, {8{16'hFF7F}}, {4{32'h7FFF1234}},
        {4{32'h8000FFFF}}, {2{64'h8000000000000001}}, {2{64'hFFFFFFFF00000000}}};
    localparam logic [VL-1:0] TV_B [NV] = '{
        {8{16'h8080}}, {8{16'h0255}}, {4{32'h7FFFABCD}},
        {4{32'h00030000}}, {2{64'h8000000000000001}}, {2{64'h00000005FFFFFFFF}}};
    localparam logic [VL-1:0] TV_X [NV] = '{
        {8{16'h4000}}, {8{16'hFFFE}}, {4{32'h3FFF0001}},
        {4{32'hFFFE8000}}, {2{64'h4000000000000000}}, {2{64'hFFFFFFFFFFFFFFFB}}};
    localparam string TV_R [NV] = '{"R5", "R1", "R2", "R2", "R3", "R3"};

    task automatic chk(input string req, input logic [VL-1:0] act, input logic [VL-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Independent bit-level model of the odd-lane widening product.
    function automatic logic [VL-1:0] ref_mul(input logic [1:0] sz,
                                               input logic [VL-1:0] a,
                                               input logic [VL-1:0] b);
        logic [VL-1:0] r;
        int es, hw;
        longint x, y, p;
        r  = '0;
        es = 8 << sz;
        hw = es / 2;
        for (int e = 0; e < VL / es; e++) begin
            for (int k = 0; k < 64; k++) begin
                x[k] = (k < hw) ? a[(2*e+1)*hw + k] : a[(2*e+1)*hw + hw - 1];
                y[k] = (k < hw) ? b[(2*e+1)*hw + k] : b[(2*e+1)*hw + hw - 1];
            end
            p = x * y;
            for (int k = 0; k < es; k++) r[e*es + k] = p[k];
        end
        return r;
    endfunction

    function automatic logic [VL-1:0] rnd_vec();
        logic [VL-1:0] v;
        for (int i = 0; i < VL / 32; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    // Drive one operation at a falling edge, then wait until its result is due.
    task automatic issue(input logic [1:0] sz, input logic [VL-1:0] a, input logic [VL-1:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_size = sz; in_op_a = a; in_op_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT - 1) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        logic [VL-1:0] keep, a, b;
        repeat (4) @(negedge clk);
        // R9: reset state
        chk("R9 valid", VL'(out_valid), '0);
        chk("R9 illegal", VL'(out_illegal), '0);
        chk("R9 result", out_result, '0);
        rst = 1'b0;

        // Vector table walk (R1, R2, R3, R5)
        for (int i = 0; i < NV; i++) begin
            issue(TV_SZ[i], TV_A[i], TV_B[i]);
            chk(TV_R[i], out_result, TV_X[i]);
            chk("R7 valid", VL'(out_valid), VL'(1));
        end

        // R7: latency exact, independent of data
        @(negedge clk);
        in_valid = 1'b1; in_size = 2'b11; in_op_a = '1; in_op_b = '1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT - 1) begin
            chk("R7 early", VL'(out_valid), '0);
            @(negedge clk);
        end
        chk("R7 on time", VL'(out_valid), VL'(1));
        chk("R3 all ones", out_result, {2{64'h1}});
        @(negedge clk);
        chk("R7 one pulse", VL'(out_valid), '0);

        // R6: reserved code right after a legal operation
        keep = {8{16'h4000}};
        issue(2'b01, {8{16'h8080}}, {8{16'h8080}});
        chk("R5 min neg", out_result, keep);
        issue(2'b00, rnd_vec(), rnd_vec());
        chk("R6 illegal", VL'(out_illegal), VL'(1));
        chk("R6 no valid", VL'(out_valid), '0);
        chk("R6 result kept", out_result, keep);

        // R8: idle cycles keep the result
        repeat (5) begin
            @(negedge clk);
            chk("R8 hold", out_result, keep);
            chk("R8 idle valid", VL'(out_valid | out_illegal), '0);
        end

        // R4: even lanes changed, odd lanes unchanged
        for (int s = 1; s < 4; s++) begin
            a = rnd_vec(); b = rnd_vec();
            issue(s[1:0], a, b);
            keep = out_result;
            for (int k = 0; k < VL; k++) begin
                if (((k / (4 << s)) % 2) == 0) begin
                    a[k] = ~a[k]; b[k] = ~b[k];
                end
            end
            issue(s[1:0], a, b);
            chk("R4 even lanes", out_result, keep);
        end

        // Random compare against reference at every legal width
        for (int s = 1; s < 4; s++) begin
            for (int t = 0; t < 30; t++) begin
                a = rnd_vec(); b = rnd_vec();
                issue(s[1:0], a, b);
                chk(s == 1 ? "R1 random" : (s == 2 ? "R2 random" : "R3 random"),
                    out_result, ref_mul(s[1:0], a, b));
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule